// File: doc/BRIEF.md
# Chip-Select Address Window Decoder

This block maps a shared memory-mapped address space onto up to five chip selects. Each chip select has a 32-bit segment register that names a window of that space in 1 MB units: a first unit and an inclusive last unit. For every address presented with a valid strobe, the decoder reports which chip select owns the address, the offset of the address inside that window, or a miss flag when no window claims it. The bus interface returns an error response on a miss.

Software programs the windows through a simple write port and can read them back through a read port. The read port is combinational. Windows are meant to rise with chip-select number and not to overlap. The decoder still gives a defined answer when they do overlap: the lowest-numbered chip select wins. A register whose first and last units are equal describes a closed window. This includes the reset value of zero. A single 1 MB window therefore cannot be expressed. The lookup result is registered and appears one clock after the address is sampled.

Top module: `cswin_decoder`

## Requirements
- R1: After a synchronous reset every segment register reads 0, and out_valid, hit_cs and miss are 0.
- R2: A write with seg_wr_sel below 5 stores bits [27:20] (last unit) and bits [11:4] (first unit) of seg_wr_data. From the next cycle all other bits read back as 0.
- R3: A write with seg_wr_sel of 5 or more changes no register. A read with seg_rd_sel of 5 or more returns 0.
- R4: A valid address hits chip select n when the window is open and first ≤ address[27:20] ≤ last. hit_cs then has exactly bit n set.
- R5: On a hit, hit_offset equals the address minus first × 1 MB.
- R6: A window is closed when first equals last, which includes a zero register, and also when first is above last. A closed window never hits.
- R7: When several windows contain the address, the lowest-numbered chip select is reported.
- R8: A valid address that no window contains gives miss = 1, hit_cs = 0 and hit_offset = 0.
- R9: Outputs follow the sampled request by exactly one cycle, including back-to-back requests. When req_valid was 0, out_valid, hit_cs and miss are 0 in the next cycle.
- R10: A lookup that is sampled on the same edge as a segment write is decoded with the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Address strobe |
| req_addr | input | 28 | Address within the shared space |
| seg_wr_en | input | 1 | Segment register write enable |
| seg_wr_sel | input | 3 | Chip select whose register is written |
| seg_wr_data | input | 32 | Write data |
| seg_rd_sel | input | 3 | Chip select whose register is read |
| seg_rd_data | output | 32 | Read data, combinational |
| out_valid | output | 1 | Registered copy of req_valid |
| hit_cs | output | 5 | One-hot chip-select hit |
| hit_offset | output | 28 | Offset inside the hit window |
| miss | output | 1 | Valid address outside every window |

## Verification
A register write and an address lookup can land on the same clock edge. This matters when the write opens the window that the lookup address falls into. The bench provokes the case by driving a write that opens chip select 3's window and a lookup into that window in the same cycle. It expects a miss for that lookup. A second lookup of the same address one cycle later must then hit chip select 3 with the correct offset. Overlapping windows, windows with first above last and pipelined back-to-back lookups are also checked against a model built from the requirements.

// File: rtl/cswin_pkg.sv
package cswin_pkg;

    localparam int SEG_W     = 32;
    localparam int FIELD_W   = 8;
    localparam int FIRST_LSB = 4;
    localparam int LAST_LSB  = 20;

    localparam logic [SEG_W-1:0] SEG_KEEP_MASK =
        (SEG_W'((1 << FIELD_W) - 1) << FIRST_LSB) |
        (SEG_W'((1 << FIELD_W) - 1) << LAST_LSB);

    typedef logic [FIELD_W-1:0] unit_t;
    typedef logic [SEG_W-1:0]   seg_word_t;

    typedef struct packed {
        unit_t last;
        unit_t first;
    } window_t;

    function automatic window_t seg_unpack(input seg_word_t word);
        window_t w;
        w.first = word[FIRST_LSB +: FIELD_W];
        w.last  = word[LAST_LSB  +: FIELD_W];
        return w;
    endfunction

    function automatic logic window_open(input window_t w);
        return w.first != w.last;
    endfunction

    function automatic logic unit_inside(input window_t w, input unit_t u);
        return window_open(w) && (u >= w.first) && (u <= w.last);
    endfunction

endpackage

// File: rtl/cswin_segregs.sv
module cswin_segregs
    import cswin_pkg::*;
#(
    parameter int NUM_CS = 5,
    parameter int SEL_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  seg_word_t               wr_data,
    input  logic [SEL_W-1:0]        rd_sel,
    output seg_word_t               rd_data,
    output window_t [NUM_CS-1:0]    windows_o
);

    seg_word_t seg_q [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst) begin
                seg_q[g] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                seg_q[g] <= wr_data & SEG_KEEP_MASK;
            end
        end

        assign windows_o[g] = seg_unpack(seg_q[g]);

        // R2
        wr_store_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_sel == SEL_W'(g)) |=>
                (seg_q[g] == ($past(wr_data) & SEG_KEEP_MASK)));

        // R3
        wr_other_stable_chk: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_sel == SEL_W'(g)) |=> $stable(seg_q[g]));
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (rd_sel == SEL_W'(i)) begin
                rd_data = seg_q[i];
            end
        end
    end

endmodule

// File: rtl/cswin_match.sv
module cswin_match
    import cswin_pkg::*;
#(
    parameter int NUM_CS = 5
) (
    input  window_t [NUM_CS-1:0] windows_i,
    input  unit_t                unit_i,
    output logic [NUM_CS-1:0]    match_o
);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
        assign match_o[g] = unit_inside(windows_i[g], unit_i);
    end

endmodule

// File: rtl/cswin_pick.sv
module cswin_pick
    import cswin_pkg::*;
#(
    parameter int NUM_CS     = 5,
    parameter int UNIT_SHIFT = 20,
    parameter int ADDR_W     = UNIT_SHIFT + FIELD_W
) (
    input  logic [NUM_CS-1:0]              match_i,
    input  logic [NUM_CS-1:0][FIELD_W-1:0] first_i,
    input  logic [ADDR_W-1:0]              addr_i,
    output logic [NUM_CS-1:0]              grant_o,
    output logic                           any_o,
    output logic [ADDR_W-1:0]              offset_o
);

    unit_t sel_first;
    unit_t addr_unit;

    assign addr_unit = addr_i[ADDR_W-1 -: FIELD_W];

    always_comb begin
        grant_o   = '0;
        any_o     = 1'b0;
        sel_first = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (match_i[i] && !any_o) begin
                grant_o[i] = 1'b1;
                any_o      = 1'b1;
                sel_first  = first_i[i];
            end
        end
    end

    always_comb begin
        offset_o = '0;
        if (any_o) begin
            offset_o = {unit_t'(addr_unit - sel_first), addr_i[UNIT_SHIFT-1:0]};
        end
    end

endmodule

// File: rtl/cswin_decoder.sv
module cswin_decoder
    import cswin_pkg::*;
#(
    parameter int NUM_CS     = 5,
    parameter int UNIT_SHIFT = 20,
    localparam int ADDR_W    = UNIT_SHIFT + FIELD_W,
    localparam int SEL_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              seg_wr_en,
    input  logic [SEL_W-1:0]  seg_wr_sel,
    input  logic [SEG_W-1:0]  seg_wr_data,
    input  logic [SEL_W-1:0]  seg_rd_sel,
    output logic [SEG_W-1:0]  seg_rd_data,
    output logic              out_valid,
    output logic [NUM_CS-1:0] hit_cs,
    output logic [ADDR_W-1:0] hit_offset,
    output logic              miss
);

    window_t [NUM_CS-1:0]              windows_w;
    logic    [NUM_CS-1:0][FIELD_W-1:0] first_w;
    logic    [NUM_CS-1:0]              match_w;
    logic    [NUM_CS-1:0]              grant_w;
    logic                              any_w;
    logic    [ADDR_W-1:0]              offset_w;

    cswin_segregs #(
        .NUM_CS (NUM_CS),
        .SEL_W  (SEL_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (seg_wr_en),
        .wr_sel    (seg_wr_sel),
        .wr_data   (seg_wr_data),
        .rd_sel    (seg_rd_sel),
        .rd_data   (seg_rd_data),
        .windows_o (windows_w)
    );

    for (genvar g = 0; g < NUM_CS; g++) begin : g_first
        assign first_w[g] = windows_w[g].first;
    end

    cswin_match #(
        .NUM_CS (NUM_CS)
    ) u_match (
        .windows_i (windows_w),
        .unit_i    (req_addr[ADDR_W-1 -: FIELD_W]),
        .match_o   (match_w)
    );

    cswin_pick #(
        .NUM_CS     (NUM_CS),
        .UNIT_SHIFT (UNIT_SHIFT),
        .ADDR_W     (ADDR_W)
    ) u_pick (
        .match_i  (match_w),
        .first_i  (first_w),
        .addr_i   (req_addr),
        .grant_o  (grant_w),
        .any_o    (any_w),
        .offset_o (offset_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            hit_cs     <= '0;
            hit_offset <= '0;
            miss       <= 1'b0;
        end else begin
            out_valid  <= req_valid;
            hit_cs     <= req_valid ? grant_w : '0;
            hit_offset <= (req_valid && any_w) ? offset_w : '0;
            miss       <= req_valid && !any_w;
        end
    end

    // R4
    hit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_cs));

    // R8
    miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
        miss |-> (out_valid && hit_cs == '0 && hit_offset == '0));

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!out_valid && hit_cs == '0 && !miss));

    for (genvar g = 0; g < NUM_CS; g++) begin : g_chk
        localparam logic [NUM_CS-1:0] LOWER = NUM_CS'((1 << g) - 1);

        // R7
        lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
            (req_valid && match_w[g] && ((match_w & LOWER) == '0)) |=> hit_cs[g]);

        // R6
        closed_never_hits_chk: assert property (@(posedge clk) disable iff (rst)
            (req_valid && windows_w[g].first == windows_w[g].last) |=> !hit_cs[g]);
    end

endmodule

// File: tb/cswin_decoder_test.sv
module cswin_decoder_test;

    localparam int NCS = 5;
    localparam int AW  = 28;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic          seg_wr_en;
    logic [2:0]    seg_wr_sel;
    logic [31:0]   seg_wr_data;
    logic [2:0]    seg_rd_sel;
    logic [31:0]   seg_rd_data;
    logic          out_valid;
    logic [NCS-1:0] hit_cs;
    logic [AW-1:0] hit_offset;
    logic          miss;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [NCS];

    always #4 clk = ~clk;

    cswin_decoder uut (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .seg_wr_en   (seg_wr_en),
        .seg_wr_sel  (seg_wr_sel),
        .seg_wr_data (seg_wr_data),
        .seg_rd_sel  (seg_rd_sel),
        .seg_rd_data (seg_rd_data),
        .out_valid   (out_valid),
        .hit_cs      (hit_cs),
        .hit_offset  (hit_offset),
        .miss        (miss)
    );

    function automatic logic [31:0] enc(input int first, input int last);
        return (32'(last) << 20) | (32'(first) << 4);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Expected result computed from R4..R8 using the bench's own register copy.
    task automatic expect_for(input logic [AW-1:0] a, output logic [NCS-1:0] cs,
                              output logic [AW-1:0] off, output logic ms);
        logic [7:0] u;
        u   = a[27:20];
        cs  = '0;
        off = '0;
        ms  = 1'b1;
        for (int i = 0; i < NCS; i++) begin
            logic [7:0] f, l;
            f = model[i][11:4];
            l = model[i][27:20];
            if (ms && f != l && u >= f && u <= l) begin
                cs[i] = 1'b1;
                off   = a - (AW'(f) << 20);
                ms    = 1'b0;
            end
        end
    endtask

    task automatic write_seg(input int sel, input logic [31:0] data);
        @(negedge clk);
        seg_wr_en   = 1'b1;
        seg_wr_sel  = 3'(sel);
        seg_wr_data = data;
        @(posedge clk);
        @(negedge clk);
        seg_wr_en = 1'b0;
        if (sel < NCS) model[sel] = data & 32'h0FF0_0FF0;
    endtask

    task automatic read_seg(input int sel, output logic [31:0] v);
        seg_rd_sel = 3'(sel);
        #1;
        v = seg_rd_data;
    endtask

    task automatic check_result(input string req, input logic [AW-1:0] a);
        logic [NCS-1:0] ecs;
        logic [AW-1:0]  eoff;
        logic           ems;
        expect_for(a, ecs, eoff, ems);
        check({req, " valid"},  32'(out_valid), 32'd1);
        check({req, " hit_cs"}, 32'(hit_cs), 32'(ecs));
        check({req, " offset"}, 32'(hit_offset), 32'(eoff));
        check({req, " miss"},   32'(miss), 32'(ems));
    endtask

    task automatic lookup(input string req, input logic [AW-1:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check_result(req, a);
    endtask

    task automatic test_reset();
        logic [31:0] v;
        check("R1 out_valid", 32'(out_valid), 0);
        check("R1 hit_cs", 32'(hit_cs), 0);
        check("R1 miss", 32'(miss), 0);
        for (int i = 0; i < NCS; i++) begin
            read_seg(i, v);
            check("R1 seg reset", v, 0);
        end
    endtask

    task automatic test_regs();
        logic [31:0] v;
        write_seg(0, 32'hFFFF_FFFF);
        read_seg(0, v);
        check("R2 masked readback", v, 32'h0FF0_0FF0);
        write_seg(0, 32'h0000_0000);
        write_seg(5, enc(1, 9));
        write_seg(7, enc(2, 9));
        for (int i = 0; i < NCS; i++) begin
            read_seg(i, v);
            check("R3 out-of-range write ignored", v, 0);
        end
        write_seg(4, enc(3, 9));
        read_seg(6, v);
        check("R3 out-of-range read", v, 0);
        read_seg(4, v);
        check("R2 field readback", v, enc(3, 9));
        write_seg(4, 0);
    endtask

    task automatic test_layout();
        write_seg(0, enc(0, 1));
        write_seg(1, enc(2, 3));
        write_seg(2, enc(4, 7));
        write_seg(3, 0);
        write_seg(4, enc(8, 8));
        lookup("R4 cs0 base", 28'h000_0000);
        lookup("R5 cs0 top", 28'h01F_FFFF);
        lookup("R4 cs1 base", 28'h020_0000);
        lookup("R5 cs1 top", 28'h03F_FFFF);
        lookup("R5 cs2 mid", 28'h056_789A);
        lookup("R6 closed equal window", 28'h080_1234);
        lookup("R8 far miss", 28'hFFF_FFFF);
        check("R6 closed miss flag", 32'(miss), 1);
    endtask

    task automatic test_overlap();
        write_seg(1, enc(0, 3));
        lookup("R7 overlap low wins", 28'h010_0004);
        check("R7 cs0 chosen", 32'(hit_cs), 32'h1);
        lookup("R7 overlap upper part", 28'h030_0010);
        write_seg(2, enc(9, 5));
        lookup("R6 reversed window", 28'h060_0000);
    endtask

    task automatic test_idle();
        repeat (2) @(negedge clk);
        check("R9 idle valid", 32'(out_valid), 0);
        check("R9 idle hit", 32'(hit_cs), 0);
        check("R9 idle miss", 32'(miss), 0);
    endtask

    task automatic test_same_cycle();
        @(negedge clk);
        seg_wr_en   = 1'b1;
        seg_wr_sel  = 3'd3;
        seg_wr_data = enc(12, 13);
        req_valid   = 1'b1;
        req_addr    = 28'h0C0_0040;
        @(posedge clk);
        @(negedge clk);
        seg_wr_en = 1'b0;
        req_valid = 1'b0;
        check("R10 lookup sees old contents (miss)", 32'(miss), 1);
        check("R10 no hit", 32'(hit_cs), 0);
        model[3] = enc(12, 13);
        lookup("R10 next lookup sees new window", 28'h0C0_0040);
        check("R10 cs3 hit", 32'(hit_cs), 32'h8);
    endtask

    task automatic test_pipeline();
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 28'h000_0123;
        @(posedge clk);
        @(negedge clk);
        check_result("R9 back-to-back first", 28'h000_0123);
        req_addr = 28'h0D1_0000;
        @(posedge clk);
        @(negedge clk);
        check_result("R9 back-to-back second", 28'h0D1_0000);
        req_addr = 28'h200_0000;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check_result("R9 back-to-back third", 28'h200_0000);
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCS; i++) model[i] = '0;
        rst         = 1'b1;
        req_valid   = 1'b0;
        req_addr    = '0;
        seg_wr_en   = 1'b0;
        seg_wr_sel  = '0;
        seg_wr_data = '0;
        seg_rd_sel  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_regs();
        test_layout();
        test_overlap();
        test_idle();
        test_same_cycle();
        test_pipeline();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule